// File: doc/BRIEF.md
# Cache Snoop Inquire Responder

This block answers external inquire (snoop) cycles on behalf of a write-back cache that keeps separate instruction and data tag arrays, each holding a MESI state per line. A bus agent presents a line address with a one-cycle strobe and an invalidate flag. The block looks the address up in both arrays and reports the result on two registered outputs. `hit` means the line is present. `hitm` means the data copy is modified and must be flushed. For a modified line it asks a bus unit for a 32-byte writeback through a request/acknowledge handshake. It applies the new MESI state only once that writeback has been acknowledged.

The block also holds the tag-state storage, so it owns the installs from line fills. A fill that is still outstanding when a matching snoop arrives is reported as a hit. That fill is then installed as shared, or not at all, instead of with the state it requested. Before a locked access, a requester asks the block to purge the locked line. A modified copy is written back first, and then every copy is invalidated, so a snoop can never find a locked line cached.

Top module: `snp_responder`

## Requirements
- R1: A snoop whose line is in neither array (including a line that shares a set index but has a different tag) drives `hit`=0 and `hitm`=0 in the following cycle, raises no `wb_req`, and leaves every cached line unchanged.
- R2: A snoop that finds a data line in shared or exclusive state drives `hit`=1 and `hitm`=0 for exactly one cycle and raises no `wb_req`.
- R3: A snoop that finds a modified data line drives `hit`=1 and `hitm`=1 and raises `wb_req`, with `wb_addr` equal to the line address and the low offset bits zero.
- R4: `hitm` is never 1 while `hit` is 0.
- R5: The instruction array stores only shared or invalid. A fill into it that requests exclusive or modified (`fill_state` 2 or 3) is stored as shared, so a snoop hit on it never raises `hitm` or `wb_req`.
- R6: After a snoop hit completes, the line is invalid if `inq_inv` was 1 and shared if it was 0, in every array that held it.
- R7: For a modified hit, `hit` and `hitm` stay 1 until `wb_ack` is sampled. They drop in the following cycle, and the state update is applied on that same edge.
- R8: A snoop that matches the line of an outstanding fill (between `fill_start` and `fill_done`, including the `fill_done` cycle) drives `hit`=1 and `hitm`=0. When that fill completes, the line is installed as shared if any matching snoop had `inq_inv`=0 and none had 1. It is not installed if any matching snoop had `inq_inv`=1.
- R9: While `lock_req` is high and the block is idle, the locked line is purged. A modified data copy first raises `wb_req` for that line. After `wb_ack`, or at once if the line is not modified, all copies become invalid and `lock_ready` pulses for one cycle.
- R10: An inquire strobe that arrives while a snoop writeback is pending is ignored: it changes no state and starts no new lookup.
- R11: After reset, `hit`, `hitm`, `wb_req` and `lock_ready` are 0 and every line in both arrays is invalid.
- R12: Once raised, `wb_req` stays 1 with `wb_addr` unchanged until `wb_ack` is sampled. It falls in the cycle after that. `fill_state` encodes 0 invalid, 1 shared, 2 exclusive, 3 modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inq_valid | input | 1 | One-cycle inquire strobe |
| inq_addr | input | ADDR_W | Inquire byte address; offset bits ignored |
| inq_inv | input | 1 | 1: invalidate on hit, 0: demote to shared |
| hit | output | 1 | Inquire found the line (or an outstanding fill of it) |
| hitm | output | 1 | Inquire found a modified data line |
| wb_req | output | 1 | Writeback request to the bus unit |
| wb_addr | output | ADDR_W | Line-aligned address of the writeback |
| wb_ack | input | 1 | Writeback complete |
| fill_start | input | 1 | A line fill begins |
| fill_icache | input | 1 | Fill targets the instruction array |
| fill_addr | input | ADDR_W | Byte address of the filled line |
| fill_state | input | 2 | Requested install state (0 I, 1 S, 2 E, 3 M) |
| fill_done | input | 1 | The outstanding fill finishes |
| lock_req | input | 1 | Purge request for a locked access, held until `lock_ready` |
| lock_addr | input | ADDR_W | Byte address of the locked line |
| lock_ready | output | 1 | One-cycle pulse: locked line purged |

## Verification
The riskiest cycle is the one in which an inquire matches the outstanding fill's line while `fill_done` is high. The snoop verdict and the install must then merge into a single write. The bench provokes this by raising the strobe and `fill_done` on the same edge for a fill that requested modified state. It judges the outcome by the `hit` pulse and by a later probe snoop, which must report a clean hit with `hitm` low. A second collision is an inquire arriving while a modified writeback is pending. There the bench checks that the ignored snoop leaves its target line present after the acknowledge.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    MESI_I = 2'd0,
    MESI_S = 2'd1,
    MESI_E = 2'd2,
    MESI_M = 2'd3
  } mesi_e;
endpackage

// File: rtl/snp_tag_array.sv
module snp_tag_array
  import snp_pkg::*;
#(
  parameter int  SETS       = 16,
  parameter int  TAG_W      = 7,
  parameter bit  WB_CAPABLE = 1'b1,
  localparam int IDX_W      = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  // lookup
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output mesi_e            rd_state,
  // conditional state update (only when the tag still matches)
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [TAG_W-1:0] upd_tag,
  input  mesi_e            upd_state,
  // fill install (replaces the set)
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [TAG_W-1:0] ins_tag,
  input  mesi_e            ins_state
);
  logic [TAG_W-1:0] tag_q [SETS];
  mesi_e            st_q  [SETS];
  mesi_e            ins_cap;

  // variant: arrays that cannot hold dirty data clamp every valid install to shared
  generate
    if (WB_CAPABLE) begin : g_wb
      assign ins_cap = ins_state;
    end else begin : g_wt
      assign ins_cap = (ins_state == MESI_I) ? MESI_I : MESI_S;
    end
  endgenerate

  assign rd_state = st_q[rd_idx];
  assign rd_hit   = (st_q[rd_idx] != MESI_I) && (tag_q[rd_idx] == rd_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) begin
        st_q[i]  <= MESI_I;
        tag_q[i] <= '0;
      end
    end else begin
      if (upd_en && st_q[upd_idx] != MESI_I && tag_q[upd_idx] == upd_tag)
        st_q[upd_idx] <= upd_state;
      if (ins_en) begin
        tag_q[ins_idx] <= ins_tag;
        st_q[ins_idx]  <= ins_cap;
      end
    end
  end
endmodule

// File: rtl/snp_fill_track.sv
module snp_fill_track
  import snp_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_ic,
  input  logic [LINE_W-1:0] start_line,
  input  mesi_e             start_state,
  input  logic              done,
  input  logic              snoop_en,
  input  logic              snoop_inv,
  input  logic [LINE_W-1:0] probe_line,
  output logic              match,
  output logic              ins_en,
  output logic              ins_ic,
  output logic [LINE_W-1:0] ins_line,
  output mesi_e             ins_state
);
  logic              act_q, ic_q, drop_q, shr_q;
  logic [LINE_W-1:0] line_q;
  mesi_e             st_q;
  logic              snoop_hit, drop_n, shr_n;

  assign match     = act_q && (line_q == probe_line);
  assign snoop_hit = snoop_en && match;
  assign drop_n    = drop_q | (snoop_hit & snoop_inv);
  assign shr_n     = shr_q | snoop_hit;

  // a snoop in the completion cycle is folded into the install
  assign ins_en    = done && act_q;
  assign ins_ic    = ic_q;
  assign ins_line  = line_q;
  assign ins_state = drop_n ? MESI_I : (shr_n ? MESI_S : st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      ic_q   <= 1'b0;
      drop_q <= 1'b0;
      shr_q  <= 1'b0;
      line_q <= '0;
      st_q   <= MESI_I;
    end else begin
      if (snoop_hit) begin
        drop_q <= drop_n;
        shr_q  <= shr_n;
      end
      if (done) act_q <= 1'b0;
      if (start) begin
        act_q  <= 1'b1;
        ic_q   <= start_ic;
        line_q <= start_line;
        st_q   <= start_state;
        drop_q <= 1'b0;
        shr_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/snp_ctrl.sv
module snp_ctrl
  import snp_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inq_valid,
  input  logic [LINE_W-1:0] inq_line,
  input  logic              inq_inv,
  input  logic              lock_req,
  input  logic [LINE_W-1:0] lock_line,
  input  logic              wb_ack,
  input  logic              fill_match,
  input  logic              i_hit,
  input  logic              d_hit,
  input  mesi_e             d_state,
  output logic [LINE_W-1:0] look_line,
  output logic              snoop_en,
  output logic              upd_en,
  output logic [LINE_W-1:0] upd_line,
  output mesi_e             upd_state,
  output logic              hit,
  output logic              hitm,
  output logic              wb_req,
  output logic [LINE_W-1:0] wb_line,
  output logic              lock_ready
);
  typedef enum logic [1:0] {PH_IDLE, PH_SNOOP_WB, PH_LOCK_WB} phase_e;
  phase_e phase_q;
  logic   inv_q;
  logic   idle, lock_go, d_dirty, any_hit;

  always_comb begin
    idle      = (phase_q == PH_IDLE);
    look_line = inq_valid ? inq_line : lock_line;
    snoop_en  = idle && inq_valid;
    lock_go   = idle && !inq_valid && lock_req && !lock_ready;
    d_dirty   = d_hit && (d_state == MESI_M);
    any_hit   = i_hit || d_hit;
    upd_en    = 1'b0;
    upd_line  = inq_line;
    upd_state = MESI_I;
    if (snoop_en && !fill_match && !d_dirty && any_hit) begin
      upd_en    = 1'b1;
      upd_state = inq_inv ? MESI_I : MESI_S;
    end else if (lock_go && !d_dirty) begin
      upd_en   = 1'b1;
      upd_line = lock_line;
    end else if (!idle && wb_ack) begin
      upd_en    = 1'b1;
      upd_line  = wb_line;
      upd_state = (phase_q == PH_SNOOP_WB && !inv_q) ? MESI_S : MESI_I;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      hit        <= 1'b0;
      hitm       <= 1'b0;
      wb_req     <= 1'b0;
      wb_line    <= '0;
      inv_q      <= 1'b0;
      lock_ready <= 1'b0;
    end else begin
      lock_ready <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          hit  <= snoop_en && (fill_match || any_hit);
          hitm <= snoop_en && !fill_match && d_dirty;
          if (snoop_en && !fill_match && d_dirty) begin
            wb_req  <= 1'b1;
            wb_line <= inq_line;
            inv_q   <= inq_inv;
            phase_q <= PH_SNOOP_WB;
          end else if (lock_go && d_dirty) begin
            wb_req  <= 1'b1;
            wb_line <= lock_line;
            phase_q <= PH_LOCK_WB;
          end else if (lock_go) begin
            lock_ready <= 1'b1;
          end
        end
        PH_SNOOP_WB: if (wb_ack) begin
          hit     <= 1'b0;
          hitm    <= 1'b0;
          wb_req  <= 1'b0;
          phase_q <= PH_IDLE;
        end
        PH_LOCK_WB: if (wb_ack) begin
          wb_req     <= 1'b0;
          lock_ready <= 1'b1;
          phase_q    <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snp_responder.sv
module snp_responder
  import snp_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inq_valid,
  input  logic [ADDR_W-1:0] inq_addr,
  input  logic              inq_inv,
  output logic              hit,
  output logic              hitm,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack,
  input  logic              fill_start,
  input  logic              fill_icache,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_state,
  input  logic              fill_done,
  input  logic              lock_req,
  input  logic [ADDR_W-1:0] lock_addr,
  output logic              lock_ready
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  logic [LINE_W-1:0] look_line, upd_line, wb_line, ins_line;
  logic              snoop_en, upd_en, fill_match, ins_en, ins_ic;
  mesi_e             upd_state, ins_state;
  logic              arr_hit   [2];
  mesi_e             arr_state [2];
  logic              unused_offsets;

  assign unused_offsets = ^{inq_addr[OFF_W-1:0], fill_addr[OFF_W-1:0], lock_addr[OFF_W-1:0]};
  assign wb_addr = {wb_line, {OFF_W{1'b0}}};

  // index 0: instruction array (clean only), index 1: data array
  for (genvar g = 0; g < 2; g++) begin : g_arr
    snp_tag_array #(
      .SETS(SETS), .TAG_W(TAG_W), .WB_CAPABLE(g == 1)
    ) u_tags (
      .clk      (clk),
      .rst      (rst),
      .rd_idx   (look_line[IDX_W-1:0]),
      .rd_tag   (look_line[LINE_W-1:IDX_W]),
      .rd_hit   (arr_hit[g]),
      .rd_state (arr_state[g]),
      .upd_en   (upd_en),
      .upd_idx  (upd_line[IDX_W-1:0]),
      .upd_tag  (upd_line[LINE_W-1:IDX_W]),
      .upd_state(upd_state),
      .ins_en   (ins_en && (ins_ic == (g == 0))),
      .ins_idx  (ins_line[IDX_W-1:0]),
      .ins_tag  (ins_line[LINE_W-1:IDX_W]),
      .ins_state(ins_state)
    );
  end

  snp_fill_track #(.LINE_W(LINE_W)) u_fill (
    .clk        (clk),
    .rst        (rst),
    .start      (fill_start),
    .start_ic   (fill_icache),
    .start_line (fill_addr[ADDR_W-1:OFF_W]),
    .start_state(mesi_e'(fill_state)),
    .done       (fill_done),
    .snoop_en   (snoop_en),
    .snoop_inv  (inq_inv),
    .probe_line (look_line),
    .match      (fill_match),
    .ins_en     (ins_en),
    .ins_ic     (ins_ic),
    .ins_line   (ins_line),
    .ins_state  (ins_state)
  );

  snp_ctrl #(.LINE_W(LINE_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .inq_valid (inq_valid),
    .inq_line  (inq_addr[ADDR_W-1:OFF_W]),
    .inq_inv   (inq_inv),
    .lock_req  (lock_req),
    .lock_line (lock_addr[ADDR_W-1:OFF_W]),
    .wb_ack    (wb_ack),
    .fill_match(fill_match),
    .i_hit     (arr_hit[0]),
    .d_hit     (arr_hit[1]),
    .d_state   (arr_state[1]),
    .look_line (look_line),
    .snoop_en  (snoop_en),
    .upd_en    (upd_en),
    .upd_line  (upd_line),
    .upd_state (upd_state),
    .hit       (hit),
    .hitm      (hitm),
    .wb_req    (wb_req),
    .wb_line   (wb_line),
    .lock_ready(lock_ready)
  );
endmodule

// File: rtl/snp_responder_chk.sv
module snp_responder_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              hit,
  input logic              hitm,
  input logic              wb_req,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              wb_ack,
  input logic              lock_ready
);
  // R4: a modified report always comes with a plain hit
  a_r4_hitm_needs_hit: assert property (@(posedge clk) disable iff (rst)
    hitm |-> hit);

  // R3: a modified report always has a writeback outstanding
  a_r3_hitm_has_wb: assert property (@(posedge clk) disable iff (rst)
    hitm |-> wb_req);

  // R12: request held until acknowledged
  a_r12_wb_hold: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> wb_req);

  // R12: writeback address stable while waiting
  a_r12_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> $stable(wb_addr));

  // R7: acknowledge ends the modified report on the next cycle
  a_r7_hitm_drop: assert property (@(posedge clk) disable iff (rst)
    (hitm && wb_ack) |=> (!hitm && !hit));

  // R9: the purge completion is a single-cycle pulse
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    lock_ready |=> !lock_ready);
endmodule

bind snp_responder snp_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .hit(hit), .hitm(hitm), .wb_req(wb_req),
  .wb_addr(wb_addr), .wb_ack(wb_ack), .lock_ready(lock_ready)
);

// File: tb/snp_responder_bench.sv
module snp_responder_bench;
  localparam int AW = 16;
  localparam int OFF = 5;
  localparam int SETS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inq_valid = 0, inq_inv = 0, wb_ack = 0;
  logic fill_start = 0, fill_icache = 0, fill_done = 0, lock_req = 0;
  logic [AW-1:0] inq_addr = '0, fill_addr = '0, lock_addr = '0;
  logic [1:0] fill_state = '0;
  logic hit, hitm, wb_req, lock_ready;
  logic [AW-1:0] wb_addr;

  int tests = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  snp_responder u_snp_responder (
    .clk(clk), .rst(rst), .inq_valid(inq_valid), .inq_addr(inq_addr),
    .inq_inv(inq_inv), .hit(hit), .hitm(hitm), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_ack(wb_ack), .fill_start(fill_start),
    .fill_icache(fill_icache), .fill_addr(fill_addr), .fill_state(fill_state),
    .fill_done(fill_done), .lock_req(lock_req), .lock_addr(lock_addr),
    .lock_ready(lock_ready)
  );

  // ---------------- behavioural reference model ----------------
  int imem[int];
  int dmem[int];
  int ms = 0, msl = 0, minv = 0;
  int fa = 0, fline = 0, fic = 0, fst = 0, fdrop = 0, fsh = 0;
  int e_hit = 0, e_hitm = 0, e_wb = 0, e_wbl = 0, e_lr = 0;

  function automatic int st_of(bit ic, int line);
    if (ic) return imem.exists(line) ? imem[line] : 0;
    return dmem.exists(line) ? dmem[line] : 0;
  endfunction

  task automatic m_update(int line, int st);
    if (imem.exists(line)) begin if (st == 0) imem.delete(line); else imem[line] = st; end
    if (dmem.exists(line)) begin if (st == 0) dmem.delete(line); else dmem[line] = st; end
  endtask

  task automatic m_install(bit ic, int line, int st);
    int victim = -1;
    if (ic) begin
      foreach (imem[k]) if ((k % SETS) == (line % SETS)) victim = k;
      if (victim >= 0) imem.delete(victim);
      if (st != 0) imem[line] = st;
    end else begin
      foreach (dmem[k]) if ((k % SETS) == (line % SETS)) victim = k;
      if (victim >= 0) dmem.delete(victim);
      if (st != 0) dmem[line] = st;
    end
  endtask

  task automatic m_step();
    int nhit = e_hit, nhitm = e_hitm, nwb = e_wb, nwbl = e_wbl, nlr = 0;
    int sl = int'(inq_addr >> OFF);
    int ll = int'(lock_addr >> OFF);
    bit snp = (ms == 0) && inq_valid;
    bit fm = (fa != 0) && (fline == sl);
    int dst = st_of(0, sl), ist = st_of(1, sl);
    bit lck = (ms == 0) && !inq_valid && lock_req && (e_lr == 0);
    if (snp) begin
      if (fm) begin
        nhit = 1; nhitm = 0; fsh = 1;
        if (inq_inv) fdrop = 1;
      end else if (dst == 3) begin
        nhit = 1; nhitm = 1; nwb = 1; nwbl = sl; msl = sl; minv = inq_inv; ms = 1;
      end else if (dst != 0 || ist != 0) begin
        nhit = 1; nhitm = 0; m_update(sl, inq_inv ? 0 : 1);
      end else begin
        nhit = 0; nhitm = 0;
      end
    end else if (ms == 0) begin
      nhit = 0; nhitm = 0;
      if (lck) begin
        if (st_of(0, ll) == 3) begin nwb = 1; nwbl = ll; msl = ll; ms = 2; end
        else begin m_update(ll, 0); nlr = 1; end
      end
    end else if (ms == 1 && wb_ack) begin
      m_update(msl, minv ? 0 : 1); nhit = 0; nhitm = 0; nwb = 0; ms = 0;
    end else if (ms == 2 && wb_ack) begin
      m_update(msl, 0); nwb = 0; nlr = 1; ms = 0;
    end
    if (fill_done && fa != 0) begin
      m_install(fic != 0, fline, fdrop ? 0 : (fsh ? 1 : fst));
      fa = 0;
    end
    if (fill_start) begin
      fa = 1; fline = int'(fill_addr >> OFF); fic = fill_icache;
      fst = fill_icache ? (fill_state != 0 ? 1 : 0) : int'(fill_state);
      fdrop = 0; fsh = 0;
    end
    e_hit = nhit; e_hitm = nhitm; e_wb = nwb; e_wbl = nwbl; e_lr = nlr;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      imem.delete(); dmem.delete();
      ms = 0; fa = 0; e_hit = 0; e_hitm = 0; e_wb = 0; e_wbl = 0; e_lr = 0;
    end else begin
      m_step();
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, cycles %0d expected <= %0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // model comparison on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", "model hit", 32'(hit), 32'(e_hit));
      chk("R3", "model hitm", 32'(hitm), 32'(e_hitm));
      chk("R12", "model wb_req", 32'(wb_req), 32'(e_wb));
      if (e_wb != 0) chk("R12", "model wb_addr", 32'(wb_addr), 32'(e_wbl << OFF));
      chk("R9", "model lock_ready", 32'(lock_ready), 32'(e_lr));
    end
  end

  function automatic logic [AW-1:0] la(int line);
    return AW'(line << OFF);
  endfunction

  task automatic snoop(int line, bit inv, bit eh, bit em, string tag);
    @(negedge clk);
    inq_valid = 1; inq_addr = la(line) | AW'(7); inq_inv = inv;
    @(negedge clk);
    inq_valid = 0;
    chk(tag, "hit", 32'(hit), 32'(eh));
    chk(tag, "hitm", 32'(hitm), 32'(em));
    chk("R4", "hitm without hit", 32'(hitm & ~hit), 32'd0);
  endtask

  task automatic ack_wb();
    repeat (2) @(negedge clk);
    chk("R7", "hitm held while pending", 32'(hitm), 32'd1);
    wb_ack = 1;
    @(negedge clk);
    wb_ack = 0;
    chk("R7", "hit after ack", 32'(hit), 32'd0);
    chk("R7", "hitm after ack", 32'(hitm), 32'd0);
    chk("R12", "wb_req after ack", 32'(wb_req), 32'd0);
  endtask

  task automatic fstart(int line, bit ic, int st);
    @(negedge clk);
    fill_start = 1; fill_addr = la(line); fill_icache = ic; fill_state = 2'(st);
    @(negedge clk);
    fill_start = 0;
  endtask

  task automatic fdone();
    @(negedge clk);
    fill_done = 1;
    @(negedge clk);
    fill_done = 0;
  endtask

  task automatic fill(int line, bit ic, int st);
    fstart(line, ic, st);
    fdone();
  endtask

  localparam int LA = 'h012, LB = 'h034, LC = 'h023, LD = 'h045, LE = 'h056;
  localparam int LF = 'h067, LG = 'h078, LH = 'h089, LJ = 'h09A, LK = 'h0AB;
  localparam int LK2 = 'h1BB, LL = 'h0CC;

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "hit in reset", 32'(hit), 32'd0);
    chk("R11", "hitm in reset", 32'(hitm), 32'd0);
    chk("R11", "wb_req in reset", 32'(wb_req), 32'd0);
    chk("R11", "lock_ready in reset", 32'(lock_ready), 32'd0);
    rst = 0;
    snoop(LA, 0, 0, 0, "R11");
    snoop(LA, 0, 0, 0, "R1");

    // exclusive data line: clean hit, then shared, then invalidated
    fill(LA, 0, 2);
    snoop(LA, 0, 1, 0, "R2");
    chk("R2", "no writeback", 32'(wb_req), 32'd0);
    @(negedge clk);
    chk("R2", "hit lasts one cycle", 32'(hit), 32'd0);
    snoop(LA, 0, 1, 0, "R6");
    snoop(LA, 1, 1, 0, "R6");
    snoop(LA, 0, 0, 0, "R6");

    // modified line: writeback, ignored snoop while pending, demote to shared
    fill(LC, 0, 1);
    fill(LB, 0, 3);
    snoop(LB, 0, 1, 1, "R3");
    chk("R3", "wb_req", 32'(wb_req), 32'd1);
    chk("R3", "wb_addr", 32'(wb_addr), 32'(la(LB)));
    @(negedge clk);
    inq_valid = 1; inq_addr = la(LC); inq_inv = 1;
    @(negedge clk);
    inq_valid = 0;
    ack_wb();
    snoop(LC, 0, 1, 0, "R10");
    snoop(LB, 0, 1, 0, "R7");

    // modified line with invalidate
    fill(LD, 0, 3);
    snoop(LD, 1, 1, 1, "R6");
    ack_wb();
    snoop(LD, 0, 0, 0, "R6");

    // instruction array never dirty
    fill(LE, 1, 3);
    snoop(LE, 0, 1, 0, "R5");
    chk("R5", "no writeback", 32'(wb_req), 32'd0);
    snoop(LE, 1, 1, 0, "R5");
    snoop(LE, 0, 0, 0, "R5");

    // snoops against an outstanding fill
    fstart(LF, 0, 3);
    snoop(LF, 0, 1, 0, "R8");
    fdone();
    snoop(LF, 0, 1, 0, "R8");
    fstart(LG, 0, 2);
    snoop(LG, 1, 1, 0, "R8");
    fdone();
    snoop(LG, 0, 0, 0, "R8");

    // snoop in the same cycle as fill completion
    fstart(LH, 0, 3);
    @(negedge clk);
    inq_valid = 1; inq_addr = la(LH); inq_inv = 0; fill_done = 1;
    @(negedge clk);
    inq_valid = 0; fill_done = 0;
    chk("R8", "hit on completing fill", 32'(hit), 32'd1);
    snoop(LH, 0, 1, 0, "R8");

    // locked line purge: modified copy written back first
    fill(LJ, 0, 3);
    @(negedge clk);
    lock_req = 1; lock_addr = la(LJ);
    @(negedge clk);
    chk("R9", "lock writeback", 32'(wb_req), 32'd1);
    chk("R9", "lock wb_addr", 32'(wb_addr), 32'(la(LJ)));
    @(negedge clk);
    wb_ack = 1;
    @(negedge clk);
    wb_ack = 0;
    chk("R9", "lock_ready after ack", 32'(lock_ready), 32'd1);
    lock_req = 0;
    snoop(LJ, 0, 0, 0, "R9");

    // locked line purge: clean copy invalidated at once
    fill(LK, 0, 1);
    @(negedge clk);
    lock_req = 1; lock_addr = la(LK);
    @(negedge clk);
    chk("R9", "lock_ready clean", 32'(lock_ready), 32'd1);
    lock_req = 0;
    snoop(LK, 0, 0, 0, "R9");

    // miss on same set leaves the resident line untouched
    fill(LK, 0, 1);
    snoop(LK2, 1, 0, 0, "R1");
    chk("R1", "no writeback on miss", 32'(wb_req), 32'd0);
    snoop(LK, 0, 1, 0, "R1");

    // every data state against both invalidate values
    for (int st = 1; st <= 3; st++) begin
      for (int inv = 0; inv <= 1; inv++) begin
        fill(LL, 0, st);
        snoop(LL, inv[0], 1, st == 3, "R6");
        if (st == 3) ack_wb();
        snoop(LL, 0, inv == 0, 0, "R6");
      end
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule